// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

A controller that was reset in the middle of a read can leave a target still shifting out data. The target then holds SDA low while SCL stays free, and no new transfer can begin. This block, on the controller side, frees such a bus. It clocks SCL itself through open-drain drive, so the target finishes its pending byte and reads a NACK. It then forces a STOP condition, which returns the target's state machine to idle.

A sequence starts in one of two ways. Software can pulse a start request. The block also starts on its own when it is idle and sees SDA low with SCL high for one full half period. The block first checks the bus, and it refuses to clock if SCL is already held low. After that check it always issues nine complete SCL pulses, whatever SDA does. It then generates the STOP and checks that both lines read high. The result is reported as a one-cycle done strobe, together with status flags that hold their value.

Top module: `i2c_bus_clear`

## Requirements
- R1: After reset both line drives are released (scl_oe_o=0, sda_oe_o=0) and busy_o, done_o, ok_o, err_scl_o and err_sda_o are 0. While the block is idle it drives neither line.
- R2: If the synchronised SCL reads low when a sequence is triggered, the block drives no pulses. One cycle later it raises done_o with err_scl_o=1 and stays idle.
- R3: A sequence drives exactly nine SCL low/high pulses. During the STOP the line rises once more, so SCL shows ten rising edges per sequence. A start request made while busy_o=1 is ignored.
- R4: Every SCL low phase, SCL high phase and STOP step lasts exactly HALF_CYC system clocks. The output enable asserts in the cycle after the trigger edge.
- R5: The STOP takes three steps. First SDA is pulled low while SCL is still low. Next SCL is released. One half period later SDA is released, and the block then waits a further half period of bus-free time. SDA is never pulled low or released while SCL is being driven high.
- R6: Each sequence ends by lowering busy_o and pulsing done_o for one cycle. Exactly one of ok_o, err_scl_o and err_sda_o is 1, and the flags hold until the next trigger. ok_o=1 when both synchronised lines read high at the end of the bus-free wait.
- R7: If either line still reads low at the end of the bus-free wait, done_o comes with err_sda_o=1 and ok_o=0.
- R8: While idle, SDA reading low with SCL high on HALF_CYC consecutive synchronised samples triggers a sequence with no start request.
- R9: A target left with 1 to 8 pending data bits, the first of them 0, releases SDA within the nine pulses. All nine pulses are still issued after the release, and the sequence ends with ok_o=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a recovery sequence (one-cycle pulse) |
| scl_i | input | 1 | SCL line level as read at the pin |
| sda_i | input | 1 | SDA line level as read at the pin |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence strobe |
| ok_o | output | 1 | Bus recovered, both lines high |
| err_scl_o | output | 1 | Aborted because SCL was low |
| err_sda_o | output | 1 | A line still low after the STOP |

## Verification
The assertions check on every cycle the following properties. The lines stay released while the block is idle. Every SCL level held during a sequence lasts HALF_CYC clocks. SDA changes only while SCL is not being driven high. The pulse count never passes nine. Each done strobe carries exactly one status flag. The bench's scenarios cover what the assertions cannot see. These include a modelled target that shifts out a random number of pending bits and then lets go, the STOP condition as seen on the wired bus, SCL held low from outside, a target that never releases SDA, and the auto-trigger from the stuck-bus pattern.

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear #(
  parameter int HALF_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic busy_o,
  output logic done_o,
  output logic ok_o,
  output logic err_scl_o,
  output logic err_sda_o
);
  localparam int CW = $clog2(HALF_CYC + 1);
  localparam logic [3:0] LAST_PULSE = 4'd8;

  typedef enum logic [2:0] {IDLE, LOW, HIGH, STP_A, STP_B, STP_C} st_t;

  st_t            state;
  logic [1:0]     scl_q, sda_q;
  logic [CW-1:0]  cnt, acnt;
  logic [3:0]     pcnt;

  wire scl_s = scl_q[1];
  wire sda_s = sda_q[1];
  wire tick  = cnt == CW'(HALF_CYC - 1);
  wire stuck = scl_s & ~sda_s;
  wire trig  = start_i | (stuck & (acnt == CW'(HALF_CYC - 1)));

  assign scl_oe_o = (state == LOW) || (state == STP_A);
  assign sda_oe_o = (state == STP_A) || (state == STP_B);
  assign busy_o   = state != IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= IDLE;
      scl_q     <= 2'b11;
      sda_q     <= 2'b11;
      cnt       <= '0;
      acnt      <= '0;
      pcnt      <= '0;
      done_o    <= 1'b0;
      ok_o      <= 1'b0;
      err_scl_o <= 1'b0;
      err_sda_o <= 1'b0;
    end else begin
      scl_q  <= {scl_q[0], scl_i};
      sda_q  <= {sda_q[0], sda_i};
      done_o <= 1'b0;
      if (state == IDLE) begin
        cnt  <= '0;
        pcnt <= '0;
        acnt <= stuck ? acnt + CW'(1) : '0;
        if (trig) begin
          acnt      <= '0;
          ok_o      <= 1'b0;
          err_sda_o <= 1'b0;
          err_scl_o <= 1'b0;
          if (!scl_s) begin
            done_o    <= 1'b1;
            err_scl_o <= 1'b1;
          end else begin
            state <= LOW;
          end
        end
      end else begin
        acnt <= '0;
        cnt  <= tick ? '0 : cnt + CW'(1);
        if (tick) begin
          case (state)
            LOW:  state <= HIGH;
            HIGH: begin
              pcnt  <= pcnt + 4'd1;
              state <= (pcnt == LAST_PULSE) ? STP_A : LOW;
            end
            STP_A: state <= STP_B;
            STP_B: state <= STP_C;
            default: begin
              state     <= IDLE;
              done_o    <= 1'b1;
              ok_o      <= scl_s & sda_s;
              err_sda_o <= ~(scl_s & sda_s);
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2c_bus_clear_chk.sv
module i2c_bus_clear_chk #(
  parameter int HALF_CYC = 250
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       scl_oe_o,
  input logic       sda_oe_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       ok_o,
  input logic       err_scl_o,
  input logic       err_sda_o,
  input logic       scl_s,
  input logic [3:0] pcnt
);
  int   run;
  logic prev_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1;
      prev_oe <= 1'b0;
    end else begin
      prev_oe <= scl_oe_o;
      run     <= (scl_oe_o != prev_oe) ? 1 : run + 1;
    end
  end

  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scl_oe_o && !sda_oe_o));

  p_scl_stuck_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_o && start_i && !scl_s) |=> (done_o && err_scl_o && !busy_o));

  p_pulse_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= 4'd9);

  p_phase_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && (scl_oe_o != prev_oe)) |-> (run == HALF_CYC));

  p_sda_low_only_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> scl_oe_o);

  p_sda_release_scl_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_o) |-> !scl_oe_o);

  p_end_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  p_one_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($countones({ok_o, err_scl_o, err_sda_o}) == 1));

  p_no_ok_with_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_o && err_sda_o));
endmodule

bind i2c_bus_clear i2c_bus_clear_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .scl_oe_o(scl_oe_o),
  .sda_oe_o(sda_oe_o), .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o),
  .err_scl_o(err_scl_o), .err_sda_o(err_sda_o), .scl_s(scl_s), .pcnt(pcnt)
);

// File: tb/test_i2c_bus_clear.sv
`timescale 1ns/1ps
module test_i2c_bus_clear;
  localparam int CLK_PERIOD = 10;
  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic scl_oe, sda_oe, busy, done, ok, err_scl, err_sda;
  logic ext_scl_low = 1'b0, dead_sda = 1'b0;
  logic tgt_active = 1'b0;
  logic [7:0] tgt_bits = '0;
  int tgt_n = 0, tgt_idx = 0;
  int errors = 0, checks = 0;
  int rises = 0, stops = 0;

  wire tgt_sda_low = tgt_active && !tgt_bits[tgt_idx[2:0]];
  wire scl_bus = !scl_oe && !ext_scl_low;
  wire sda_bus = !sda_oe && !tgt_sda_low && !dead_sda;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_bus_clear #(.HALF_CYC(H)) i_i2c_bus_clear (
    .clk(clk), .rst_n(rst_n), .start_i(start), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy), .done_o(done),
    .ok_o(ok), .err_scl_o(err_scl), .err_sda_o(err_sda));

  // target: next pending bit on each SCL fall, lets go after the last one
  always @(negedge scl_bus) if (tgt_active) begin
    tgt_idx = tgt_idx + 1;
    if (tgt_idx >= tgt_n) tgt_active = 1'b0;
  end
  always @(posedge scl_bus) rises = rises + 1;
  always @(posedge sda_bus) if (scl_bus) stops = stops + 1;

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model
  bit m_busy, m_done, m_ok, m_es, m_ed;
  int m_el, m_run;
  bit h1s, h1d, h2s, h2d;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_ok = 0; m_es = 0; m_ed = 0;
      m_el = 0; m_run = 0; h1s = 1; h1d = 1; h2s = 1; h2d = 1;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        bit trig;
        m_run = (h2s && !h2d) ? m_run + 1 : 0;
        trig = start || (m_run == H);
        if (trig) begin
          m_run = 0; m_ok = 0; m_es = 0; m_ed = 0;
          if (!h2s) begin m_done = 1; m_es = 1; end
          else begin m_busy = 1; m_el = 0; end
        end
      end else begin
        m_run = 0;
        m_el = m_el + 1;
        if (m_el == 21*H) begin
          m_busy = 0; m_done = 1;
          m_ok = h2s && h2d; m_ed = !(h2s && h2d);
        end
      end
      h2s = h1s; h2d = h1d; h1s = scl_bus; h1d = sda_bus;
    end
  end

  always @(negedge clk) if (rst_n) begin
    int p;
    bit e_scl, e_sda;
    p = m_el / H;
    e_scl = m_busy && ((p < 18) ? (p % 2 == 0) : (p == 18));
    e_sda = m_busy && (p == 18 || p == 19);
    check("R4 scl_oe timing", scl_oe, e_scl);
    check("R5 sda_oe STOP", sda_oe, e_sda);
    check("R3 busy", busy, m_busy);
    check("R6 done", done, m_done);
    check("R6 ok", ok, m_ok);
    check("R2 err_scl", err_scl, m_es);
    check("R7 err_sda", err_sda, m_ed);
  end

  task automatic wait_done();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done) return;
    end
    check("R6 done timeout", 0, 1);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic arm_target();
    tgt_n = 1 + int'($urandom_range(7));
    tgt_bits = 8'($urandom);
    tgt_bits[0] = 1'b0;
    tgt_idx = 0;
    tgt_active = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    errors = errors + 1;
    $display("FAIL R3 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset scl_oe", scl_oe, 0);
    check("R1 reset sda_oe", sda_oe, 0);
    check("R1 reset status", {busy, done, ok, err_scl, err_sda}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // free bus, start request, extra start while busy
    rises = 0; stops = 0;
    pulse_start();
    repeat (20) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done();
    check("R6 ok free bus", ok, 1);
    check("R3 scl rises", rises, 10);
    check("R5 stop seen", stops, 1);
    repeat (10) @(negedge clk);

    // stuck target, auto trigger
    for (int k = 0; k < 5; k++) begin
      rises = 0; stops = 0;
      @(negedge clk); arm_target();
      repeat (H + 3) @(negedge clk);
      check("R8 auto trigger busy", busy, 1);
      wait_done();
      check("R9 target released", tgt_active, 0);
      check("R9 all pulses issued", rises, 10);
      check("R5 stop seen", stops, 1);
      check("R6 ok after recovery", ok, 1);
      repeat (10) @(negedge clk);
    end

    // stuck target with explicit start
    rises = 0; stops = 0;
    @(negedge clk); arm_target(); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
    check("R9 released via start", tgt_active, 0);
    check("R9 pulses via start", rises, 10);
    repeat (10) @(negedge clk);

    // SCL held low externally
    rises = 0;
    @(negedge clk); ext_scl_low = 1'b1;
    repeat (4) @(negedge clk);
    pulse_start();
    check("R2 abort err_scl", err_scl, 1);
    check("R2 abort busy", busy, 0);
    repeat (5) @(negedge clk);
    check("R2 no scl drive", scl_oe, 0);
    ext_scl_low = 1'b0;
    repeat (10) @(negedge clk);
    check("R2 no pulses", rises, 1);

    // target never lets go
    rises = 0; stops = 0;
    @(negedge clk); dead_sda = 1'b1;
    wait_done();
    dead_sda = 1'b0;
    check("R7 still stuck", err_sda, 1);
    check("R7 no ok", ok, 0);
    check("R7 no stop on bus", stops, 0);
    repeat (20) @(negedge clk);
    check("R1 idle no drive", {scl_oe, sda_oe, busy}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule